// File: doc/BRIEF.md
# Packet Crossbar Switch with Fixed-Priority Output Allocation

This block is a full N-by-N crossbar that moves framed packets from any input port to any output port. Each port carries a 32-bit word with start-of-frame and end-of-frame markers, a source-ready flag from the sender and a destination-ready flag from the receiver. A routing unit beside each input presents a request together with the index of the wanted output. The allocator gives every free output to one of the inputs asking for it. When several inputs ask for the same output, the lowest-numbered input wins. Different outputs are handed out in the same cycle.

Once an input has been granted an output, that input owns the output until the last beat of its packet has been accepted. The input then gives the output up and the output is offered again. Each output has one register stage, so a beat taken from an input appears on the output one clock later. The destination-ready of the output is returned to whichever input owns it. A routing unit keeps its request asserted until it sees its grant, and then drops the request.

Top module: `pkt_xbar`

## Requirements
- R1: While reset is asserted (rst_n low, sampled on the clock), out_srdy, in_gnt and in_drdy are all zero.
- R2: An input i that requests output o (in_req[i]=1, in_dest[i]=o) while o has no owner sees in_gnt[i] high after the next rising edge.
- R3: A beat that an owning input offers (in_srdy=1) while its in_drdy is high is registered at that edge. It appears on the owned output with out_srdy=1 after that same edge, exactly one cycle of latency.
- R4: When several inputs request the same free output in one cycle, only the lowest-numbered of them is granted.
- R5: Requests for different free outputs in the same cycle are all granted at the same edge.
- R6: While a packet is in progress, ownership of the output does not change and no other requester is granted it.
- R7: The edge that accepts the owner's end-of-frame beat frees the output (in_gnt of that input drops). A waiting requester is granted at the following edge.
- R8: While out_srdy[o]=1 and out_drdy[o]=0, the output word and its flags are held, and in_drdy of the owning input is low.
- R9: An output with no owner never raises out_srdy for new data, and an input without a grant sees in_drdy low.
- R10: The 32 data bits, start-of-frame and end-of-frame pass to the output unchanged. Data occupies bits [32*p+31:32*p] of the flat data buses for port p.
- R11: A request from an input that already owns an output is ignored. A lower-priority input asking for the same output is granted instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | NPORTS | Per-input request for an output |
| in_dest | input | NPORTS*IDXW | Per-input requested output index |
| in_data | input | NPORTS*32 | Per-input data word |
| in_sof | input | NPORTS | Per-input start-of-frame |
| in_eof | input | NPORTS | Per-input end-of-frame |
| in_srdy | input | NPORTS | Per-input source-ready |
| in_drdy | output | NPORTS | Ready returned to each input from its owned output |
| in_gnt | output | NPORTS | Input currently owns an output |
| out_data | output | NPORTS*32 | Per-output data word |
| out_sof | output | NPORTS | Per-output start-of-frame |
| out_eof | output | NPORTS | Per-output end-of-frame |
| out_srdy | output | NPORTS | Per-output source-ready |
| out_drdy | input | NPORTS | Per-output destination-ready |

## Verification
The hardest condition to reach is the hand-over of an output from one packet to the next while other inputs are still waiting. This involves the release edge, the one idle owner cycle and the re-grant, with a lower-priority input already queued. The stimulus sets up three inputs that contend for one output. Each winner sends a single-beat packet and the bench watches ownership move in priority order, one edge at a time. A separate scenario stalls the output with the second beat of a packet already offered, so that the hold and ready-return paths are exercised against a full register.

// File: rtl/pkt_xbar_pkg.sv
// Shared constants and the beat type for the packet crossbar.
// Assumes a fixed 32-bit word with two framing flags per beat.
package pkt_xbar_pkg;
    localparam int XB_DW = 32;

    typedef struct packed {
        logic             sof;
        logic             eof;
        logic [XB_DW-1:0] data;
    } xb_beat_t;
endpackage

// File: rtl/xbar_alloc.sv
// Output allocator: one one-hot owner register per output.
// A free output is granted to the lowest-numbered eligible requester.
// Inputs that already own an output are not eligible. The owner clears
// on the edge that accepts the end-of-frame beat.
module xbar_alloc #(
    parameter int NPORTS = 6,
    parameter int IDXW   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORTS-1:0]      in_req,
    input  logic [NPORTS*IDXW-1:0] in_dest,
    input  logic [NPORTS-1:0]      eof_done,
    output logic [NPORTS*NPORTS-1:0] owner_flat,
    output logic [NPORTS-1:0]      in_busy
);
    logic [NPORTS-1:0] owner_q [NPORTS];
    logic [NPORTS-1:0] req_col [NPORTS];
    logic [NPORTS-1:0] pick    [NPORTS];

    // Marks inputs that already own some output.
    always_comb begin
        in_busy = '0;
        for (int o = 0; o < NPORTS; o++) begin
            in_busy = in_busy | owner_q[o];
        end
    end

    genvar o;
    generate
        for (o = 0; o < NPORTS; o++) begin : g_out
            // Builds the request column for this output.
            always_comb begin
                for (int i = 0; i < NPORTS; i++) begin
                    req_col[o][i] = in_req[i] && !in_busy[i] &&
                                    (in_dest[i*IDXW +: IDXW] == IDXW'(o));
                end
            end

            // Fixed priority: isolates the lowest set request bit.
            assign pick[o] = req_col[o] & (~req_col[o] + NPORTS'(1));

            // Holds, releases or grants ownership of this output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    owner_q[o] <= '0;
                end else if (owner_q[o] == '0) begin
                    owner_q[o] <= pick[o];
                end else if (eof_done[o]) begin
                    owner_q[o] <= '0;
                end
            end

            assign owner_flat[o*NPORTS +: NPORTS] = owner_q[o];
        end
    endgenerate
endmodule

// File: rtl/xbar_outport.sv
// One output of the crossbar: it selects the owner's beat and holds it
// in a single register stage. Ready is passed back when the register is
// empty or is being drained. Assumes that the owner vector is one-hot or zero.
module xbar_outport
    import pkt_xbar_pkg::*;
#(
    parameter int NPORTS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORTS-1:0]     own,
    input  xb_beat_t [NPORTS-1:0] in_beat,
    input  logic [NPORTS-1:0]     in_srdy,
    input  logic                  out_drdy,
    output xb_beat_t              out_beat,
    output logic                  out_srdy,
    output logic                  fwd_rdy,
    output logic                  eof_done
);
    xb_beat_t sel_beat;
    logic     sel_srdy;
    logic     take;
    logic     v_q;
    xb_beat_t beat_q;

    // AND-OR multiplexer over the owner's beat.
    always_comb begin
        sel_beat = '0;
        for (int i = 0; i < NPORTS; i++) begin
            sel_beat = sel_beat | (own[i] ? in_beat[i] : '0);
        end
    end

    assign sel_srdy = |(own & in_srdy);
    assign take     = !v_q || out_drdy;
    assign fwd_rdy  = take && (own != '0);
    assign eof_done = take && sel_srdy && sel_beat.eof;

    // Output register: loads when empty or when the downstream accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            beat_q <= '0;
        end else if (take) begin
            v_q <= sel_srdy;
            if (sel_srdy) begin
                beat_q <= sel_beat;
            end
        end
    end

    assign out_beat = beat_q;
    assign out_srdy = v_q;
endmodule

// File: rtl/xbar_ready_ret.sv
// Ready return: each input gets the ready of the output it owns.
// Also reports which inputs hold a grant. Assumes each input owns at most one output.
module xbar_ready_ret #(
    parameter int NPORTS = 6
) (
    input  logic [NPORTS*NPORTS-1:0] owner_flat,
    input  logic [NPORTS-1:0]        fwd_rdy,
    output logic [NPORTS-1:0]        in_drdy,
    output logic [NPORTS-1:0]        in_gnt
);
    // Folds the owner matrix along the outputs.
    always_comb begin
        in_drdy = '0;
        in_gnt  = '0;
        for (int o = 0; o < NPORTS; o++) begin
            in_gnt  = in_gnt | owner_flat[o*NPORTS +: NPORTS];
            in_drdy = in_drdy |
                      (owner_flat[o*NPORTS +: NPORTS] & {NPORTS{fwd_rdy[o]}});
        end
    end
endmodule

// File: rtl/pkt_xbar.sv
// Top of the packet crossbar. It joins the allocator, one registered
// output stage per port and the ready return. Routing units outside
// supply a request and an output index per input.
module pkt_xbar
    import pkt_xbar_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int DW     = XB_DW,
    parameter int IDXW   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORTS-1:0]      in_req,
    input  logic [NPORTS*IDXW-1:0] in_dest,
    input  logic [NPORTS*DW-1:0]   in_data,
    input  logic [NPORTS-1:0]      in_sof,
    input  logic [NPORTS-1:0]      in_eof,
    input  logic [NPORTS-1:0]      in_srdy,
    output logic [NPORTS-1:0]      in_drdy,
    output logic [NPORTS-1:0]      in_gnt,
    output logic [NPORTS*DW-1:0]   out_data,
    output logic [NPORTS-1:0]      out_sof,
    output logic [NPORTS-1:0]      out_eof,
    output logic [NPORTS-1:0]      out_srdy,
    input  logic [NPORTS-1:0]      out_drdy
);
    logic [NPORTS*NPORTS-1:0] owner_flat;
    logic [NPORTS-1:0]        eof_done;
    logic [NPORTS-1:0]        fwd_rdy;
    logic [NPORTS-1:0]        in_busy;
    xb_beat_t [NPORTS-1:0]    in_beat;
    xb_beat_t [NPORTS-1:0]    out_beat;

    xbar_alloc #(.NPORTS(NPORTS), .IDXW(IDXW)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_req     (in_req),
        .in_dest    (in_dest),
        .eof_done   (eof_done),
        .owner_flat (owner_flat),
        .in_busy    (in_busy)
    );

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_port
            // Packs the flat input buses into beats.
            assign in_beat[p].sof  = in_sof[p];
            assign in_beat[p].eof  = in_eof[p];
            assign in_beat[p].data = in_data[p*DW +: DW];

            xbar_outport #(.NPORTS(NPORTS)) u_outport (
                .clk      (clk),
                .rst_n    (rst_n),
                .own      (owner_flat[p*NPORTS +: NPORTS]),
                .in_beat  (in_beat),
                .in_srdy  (in_srdy),
                .out_drdy (out_drdy[p]),
                .out_beat (out_beat[p]),
                .out_srdy (out_srdy[p]),
                .fwd_rdy  (fwd_rdy[p]),
                .eof_done (eof_done[p])
            );

            // Unpacks the output beats onto the flat buses.
            assign out_data[p*DW +: DW] = out_beat[p].data;
            assign out_sof[p]           = out_beat[p].sof;
            assign out_eof[p]           = out_beat[p].eof;
        end
    endgenerate

    xbar_ready_ret #(.NPORTS(NPORTS)) u_ret (
        .owner_flat (owner_flat),
        .fwd_rdy    (fwd_rdy),
        .in_drdy    (in_drdy),
        .in_gnt     (in_gnt)
    );
endmodule

// File: rtl/pkt_xbar_chk.sv
// Property checker for the packet crossbar. It observes ownership,
// release, stall and ready behaviour, and is bound to pkt_xbar.
module pkt_xbar_chk #(
    parameter int NPORTS = 6,
    parameter int DW     = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORTS*NPORTS-1:0] owner_flat,
    input logic [NPORTS-1:0]        eof_done,
    input logic [NPORTS-1:0]        in_gnt,
    input logic [NPORTS-1:0]        in_drdy,
    input logic [NPORTS-1:0]        out_srdy,
    input logic [NPORTS-1:0]        out_drdy,
    input logic [NPORTS*DW-1:0]     out_data
);
    genvar o, i;
    generate
        for (o = 0; o < NPORTS; o++) begin : g_o
            // R4: a single winner per output.
            p_owner_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(owner_flat[o*NPORTS +: NPORTS]));
            // R6: ownership is frozen until the packet ends.
            p_hold_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (owner_flat[o*NPORTS +: NPORTS] != '0) && !eof_done[o]
                |=> $stable(owner_flat[o*NPORTS +: NPORTS]));
            // R7: the accepted end-of-frame beat frees the output.
            p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
                eof_done[o] |=> (owner_flat[o*NPORTS +: NPORTS] == '0));
            // R8: a stalled output holds its word.
            p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                out_srdy[o] && !out_drdy[o]
                |=> out_srdy[o] && $stable(out_data[o*DW +: DW]));
        end
        for (i = 0; i < NPORTS; i++) begin : g_i
            logic [NPORTS-1:0] col;
            for (o = 0; o < NPORTS; o++) begin : g_col
                assign col[o] = owner_flat[o*NPORTS + i];
            end
            // R11: an input owns at most one output.
            p_one_output_r11: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(col) <= 1);
            // R9: ready reaches only inputs that hold a grant.
            p_ready_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
                in_drdy[i] |-> in_gnt[i]);
        end
    endgenerate
endmodule

bind pkt_xbar pkt_xbar_chk #(.NPORTS(NPORTS), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .owner_flat (owner_flat),
    .eof_done   (eof_done),
    .in_gnt     (in_gnt),
    .in_drdy    (in_drdy),
    .out_srdy   (out_srdy),
    .out_drdy   (out_drdy),
    .out_data   (out_data)
);

// File: tb/pkt_xbar_tb.sv
// Directed bench for pkt_xbar: one task per scenario. Inputs are driven
// on the falling edge and outputs are checked on the next falling edge.
module pkt_xbar_tb;
    localparam int N  = 6;
    localparam int DW = 32;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_req = '0;
    logic [N*IW-1:0] in_dest = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    in_sof = '0, in_eof = '0, in_srdy = '0;
    logic [N-1:0]    in_drdy, in_gnt;
    logic [N*DW-1:0] out_data;
    logic [N-1:0]    out_sof, out_eof, out_srdy;
    logic [N-1:0]    out_drdy = '1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pkt_xbar #(.NPORTS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_dest(in_dest),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_srdy(in_srdy), .in_drdy(in_drdy), .in_gnt(in_gnt),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_srdy(out_srdy), .out_drdy(out_drdy)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ask(input int i, input int dst);
        in_req[i] = 1'b1;
        in_dest[i*IW +: IW] = IW'(dst);
    endtask

    task automatic beat(input int i, input logic [31:0] d, input logic s,
                        input logic e, input logic v);
        in_data[i*DW +: DW] = d;
        in_sof[i] = s;
        in_eof[i] = e;
        in_srdy[i] = v;
    endtask

    task automatic t_reset();
        step(); step();
        check("R1 out_srdy", 32'(out_srdy), 32'h0);
        check("R1 in_gnt", 32'(in_gnt), 32'h0);
        check("R1 in_drdy", 32'(in_drdy), 32'h0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_idle();
        beat(0, 32'hDEAD0000, 1'b1, 1'b1, 1'b1);
        step();
        check("R9 no owner srdy", 32'(out_srdy), 32'h0);
        check("R9 no grant drdy", 32'(in_drdy[0]), 32'h0);
        beat(0, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
    endtask

    task automatic t_single();
        ask(2, 4);
        step();
        check("R2 grant", 32'(in_gnt), 32'h04);
        check("R3 ready to owner", 32'(in_drdy[2]), 32'h1);
        in_req[2] = 1'b0;
        beat(2, 32'hA5A51234, 1'b1, 1'b0, 1'b1);
        step();
        check("R3 latency srdy", 32'(out_srdy), 32'h10);
        check("R10 data", out_data[4*DW +: DW], 32'hA5A51234);
        check("R10 sof", 32'(out_sof[4]), 32'h1);
        beat(2, 32'h0BADF00D, 1'b0, 1'b1, 1'b1);
        step();
        check("R10 eof beat data", out_data[4*DW +: DW], 32'h0BADF00D);
        check("R10 eof", 32'(out_eof[4]), 32'h1);
        check("R7 released", 32'(in_gnt), 32'h0);
        beat(2, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
        check("R9 drained", 32'(out_srdy), 32'h0);
    endtask

    task automatic t_prio();
        ask(5, 0); ask(3, 0); ask(1, 0);
        step();
        check("R4 lowest wins", 32'(in_gnt), 32'h02);
        in_req[1] = 1'b0;
        beat(1, 32'h11110001, 1'b1, 1'b1, 1'b1);
        step();
        check("R7 freed at eof edge", 32'(in_gnt), 32'h0);
        check("R3 out0 data", out_data[0 +: DW], 32'h11110001);
        beat(1, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
        check("R7 regrant next", 32'(in_gnt), 32'h08);
        in_req[3] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R6 held while open", 32'(in_gnt), 32'h08);
        end
        beat(3, 32'h33330003, 1'b1, 1'b1, 1'b1);
        step();
        check("R6 out0 from in3", out_data[0 +: DW], 32'h33330003);
        beat(3, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
        check("R4 next in order", 32'(in_gnt), 32'h20);
        in_req[5] = 1'b0;
        beat(5, 32'h55550005, 1'b1, 1'b1, 1'b1);
        step();
        beat(5, 32'h0, 1'b0, 1'b0, 1'b0);
        check("R7 last release", 32'(in_gnt), 32'h0);
        step();
    endtask

    task automatic t_parallel();
        ask(0, 1); ask(2, 3); ask(4, 5);
        step();
        check("R5 parallel grants", 32'(in_gnt), 32'h15);
        in_req = '0;
        beat(0, 32'hC0C00000, 1'b1, 1'b1, 1'b1);
        beat(2, 32'hC2C20002, 1'b1, 1'b1, 1'b1);
        beat(4, 32'hC4C40004, 1'b1, 1'b1, 1'b1);
        step();
        check("R5 parallel outputs", 32'(out_srdy), 32'h2A);
        check("R5 out1", out_data[1*DW +: DW], 32'hC0C00000);
        check("R5 out3", out_data[3*DW +: DW], 32'hC2C20002);
        check("R5 out5", out_data[5*DW +: DW], 32'hC4C40004);
        beat(0, 32'h0, 1'b0, 1'b0, 1'b0);
        beat(2, 32'h0, 1'b0, 1'b0, 1'b0);
        beat(4, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
    endtask

    task automatic t_backpressure();
        ask(4, 2);
        step();
        in_req[4] = 1'b0;
        out_drdy[2] = 1'b0;
        beat(4, 32'hF0F0000F, 1'b1, 1'b0, 1'b1);
        step();
        check("R8 first beat in reg", out_data[2*DW +: DW], 32'hF0F0000F);
        check("R8 owner not ready", 32'(in_drdy[4]), 32'h0);
        beat(4, 32'h6666000F, 1'b0, 1'b1, 1'b1);
        step();
        check("R8 word held", out_data[2*DW +: DW], 32'hF0F0000F);
        check("R8 still stalled", 32'(out_srdy[2]), 32'h1);
        check("R6 grant kept in stall", 32'(in_gnt), 32'h10);
        out_drdy[2] = 1'b1;
        step();
        check("R8 drains to next", out_data[2*DW +: DW], 32'h6666000F);
        check("R7 stall release", 32'(in_gnt), 32'h0);
        beat(4, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
    endtask

    task automatic t_busy_ignore();
        ask(0, 3);
        step();
        ask(0, 5); ask(1, 5);
        step();
        check("R11 busy input ignored", 32'(in_gnt), 32'h03);
        in_req = '0;
        beat(0, 32'hB0B00000, 1'b1, 1'b1, 1'b1);
        beat(1, 32'hB1B10001, 1'b1, 1'b1, 1'b1);
        step();
        check("R11 out5 from in1", out_data[5*DW +: DW], 32'hB1B10001);
        check("R11 out3 from in0", out_data[3*DW +: DW], 32'hB0B00000);
        beat(0, 32'h0, 1'b0, 1'b0, 1'b0);
        beat(1, 32'h0, 1'b0, 1'b0, 1'b0);
        step();
    endtask

    initial begin
        t_reset();
        t_idle();
        t_single();
        t_prio();
        t_parallel();
        t_backpressure();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule